// File: doc/BRIEF.md
# Synchronous exception and debug entry dispatcher

This block sits beside a processor's special-register file and turns a synchronous exception request, or a debug request, into one selected vector and one set of saved-state updates. A general request carries a kind, a cause code, the faulting PC, an optional virtual address and a fetch/data flag. The block classifies alignment faults and bus errors into fixed cause codes, picks the user, kernel or double-exception vector from the current processor status word (PS), and saves the PC, cause and address. A debug request saves the PC and the old PS in the bank slot of the configured debug level, provided the current interrupt level is below that level.

The general request is a valid/ready stream. `req_ready` is high in every cycle except one in which a debug request is taken. In that cycle the general request must be held, and it is accepted in a later cycle with `req_ready` high. The debug request and the PS write port are plain one-cycle strobes. All updates, and a one-cycle vector pulse, appear in the cycle after the request is accepted.

Top module: `exc_dispatch`

## Requirements
- R1: After reset every saved-state output is zero and `vec_pulse` is zero.
- R2: With PS.EXCM (bit 4) clear, an accepted general exception stores its PC in `epc1`. In the next cycle it pulses `vec_pulse` bit 0 (user) if PS.UM (bit 5) is set, and bit 1 (kernel) otherwise.
- R3: With PS.EXCM set, an accepted general exception pulses bit 2 (double). With a DEPC register configured, the PC goes to `depc` and `epc1` keeps its value; without one, the PC goes to `epc1`.
- R4: Every taken general exception writes its cause to `exccause` and sets PS.EXCM, leaving PS.UM and PS.INTLEVEL (bits 3:0) unchanged.
- R5: Kind 1 (address fault) writes `req_vaddr` into `excvaddr`. Kind 0 (plain) leaves `excvaddr` unchanged.
- R6: Kind 2 (misaligned access) raises cause 9 with `req_vaddr` saved only when `cfg_unaligned_exc` is 1 and `cfg_hw_align` is 0. Otherwise the request is consumed and has no effect on any output.
- R7: Kind 3 (bus error) with `req_is_fetch`=1 raises cause 12 and saves `req_pc` as the address. With `req_is_fetch`=0 it raises cause 13 and saves `req_vaddr`.
- R8: A debug request is taken only when PS.INTLEVEL is strictly below DBG_LEVEL. Otherwise it has no effect.
- R9: A taken debug request writes `debugcause`, stores its PC in `epc_lvl[DBG_LEVEL-2]` and the old PS in `eps_lvl[DBG_LEVEL-2]`, sets PS.INTLEVEL to DBG_LEVEL and sets PS.EXCM, keeps PS.UM, and pulses bit 3 (debug).
- R10: A taken debug request wins over a general request in the same cycle. `req_ready` is low in that cycle, and the general request that is held is taken afterwards under the new PS.
- R11: At most one bit of `vec_pulse` is high at a time, and each pulse lasts one cycle.
- R12: `ps_wr_en` loads `ps_wr_data` into PS only in a cycle where no exception or debug request is taken. Otherwise it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | General exception request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_kind | input | 2 | 0 plain, 1 address fault, 2 misaligned, 3 bus error |
| req_cause | input | CAUSE_W | Cause for kinds 0 and 1 |
| req_pc | input | XLEN | Faulting PC |
| req_vaddr | input | XLEN | Faulting data virtual address |
| req_is_fetch | input | 1 | Bus error came from instruction fetch |
| cfg_unaligned_exc | input | 1 | Unaligned-exception support enabled |
| cfg_hw_align | input | 1 | Hardware alignment handling enabled |
| dbg_valid | input | 1 | Debug request strobe |
| dbg_cause | input | DCAUSE_W | Debug cause |
| dbg_pc | input | XLEN | PC at debug request |
| ps_wr_en | input | 1 | PS write strobe |
| ps_wr_data | input | ILVL_W+2 | New PS value |
| vec_pulse | output | 4 | One-hot vector select: user, kernel, double, debug |
| ps | output | ILVL_W+2 | PS: INTLEVEL, EXCM, UM |
| epc1 | output | XLEN | Saved PC, level 1 |
| depc | output | XLEN | Saved PC for double exceptions |
| exccause | output | CAUSE_W | Saved cause |
| excvaddr | output | XLEN | Saved faulting address |
| debugcause | output | DCAUSE_W | Saved debug cause |
| epc_lvl | output | (NUM_LEVELS-1)*XLEN | Saved PC per level 2..NUM_LEVELS |
| eps_lvl | output | (NUM_LEVELS-1)*(ILVL_W+2) | Saved PS per level 2..NUM_LEVELS |

## Verification
The hardest case is a debug request and a general request meeting in one cycle while the interrupt level allows debug. The bench has to see `req_ready` drop, keep the request asserted, and then check that the late acceptance goes to the double vector because debug entry has set EXCM. The stimulus gets there by clearing PS through the write port, raising both requests in the same cycle, and repeating the general request in the next one. The mirror case, where the interrupt level is at or above the debug level, is also driven so that the general request passes through untouched.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [1:0] {
    KIND_PLAIN    = 2'd0,
    KIND_ADDR     = 2'd1,
    KIND_MISALIGN = 2'd2,
    KIND_BUSERR   = 2'd3
  } req_kind_e;

  localparam int VEC_W      = 4;
  localparam int VEC_USER   = 0;
  localparam int VEC_KERNEL = 1;
  localparam int VEC_DOUBLE = 2;
  localparam int VEC_DEBUG  = 3;

  localparam int CAUSE_ALIGN     = 9;
  localparam int CAUSE_FETCH_BUS = 12;
  localparam int CAUSE_DATA_BUS  = 13;
endpackage

// File: rtl/exc_classify.sv
module exc_classify
  import exc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 6
) (
  input  logic               req_on,
  input  logic [1:0]         kind,
  input  logic [CAUSE_W-1:0] cause_in,
  input  logic [XLEN-1:0]    pc,
  input  logic [XLEN-1:0]    vaddr_in,
  input  logic               is_fetch,
  input  logic               unaligned_en,
  input  logic               hw_align,
  output logic               take,
  output logic [CAUSE_W-1:0] cause_out,
  output logic               vaddr_we,
  output logic [XLEN-1:0]    vaddr_out
);
  req_kind_e k;
  logic      align_trap;

  assign k          = req_kind_e'(kind);
  assign align_trap = unaligned_en & ~hw_align;

  always_comb begin
    take      = 1'b0;
    cause_out = cause_in;
    vaddr_we  = 1'b0;
    vaddr_out = vaddr_in;
    if (req_on) begin
      unique case (k)
        KIND_PLAIN: begin
          take = 1'b1;
        end
        KIND_ADDR: begin
          take     = 1'b1;
          vaddr_we = 1'b1;
        end
        KIND_MISALIGN: begin
          take      = align_trap;
          vaddr_we  = align_trap;
          cause_out = CAUSE_W'(CAUSE_ALIGN);
        end
        KIND_BUSERR: begin
          take      = 1'b1;
          vaddr_we  = 1'b1;
          cause_out = is_fetch ? CAUSE_W'(CAUSE_FETCH_BUS) : CAUSE_W'(CAUSE_DATA_BUS);
          vaddr_out = is_fetch ? pc : vaddr_in;
        end
        default: take = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/exc_dbg_gate.sv
module exc_dbg_gate #(
  parameter int ILVL_W    = 4,
  parameter int DBG_LEVEL = 6
) (
  input  logic              dbg_valid,
  input  logic [ILVL_W-1:0] cur_level,
  output logic              dbg_take
);
  localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);

  assign dbg_take = dbg_valid & (cur_level < LVL);
endmodule

// File: rtl/exc_state.sv
module exc_state
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int DCAUSE_W   = 6,
  parameter int ILVL_W     = 4,
  parameter int NUM_LEVELS = 7,
  parameter int DBG_LEVEL  = 6,
  parameter bit HAS_DEPC   = 1'b1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         gen_take,
  input  logic [CAUSE_W-1:0]           gen_cause,
  input  logic [XLEN-1:0]              gen_pc,
  input  logic                         gen_vaddr_we,
  input  logic [XLEN-1:0]              gen_vaddr,
  input  logic                         dbg_take,
  input  logic [DCAUSE_W-1:0]          dbg_cause,
  input  logic [XLEN-1:0]              dbg_pc,
  input  logic                         ps_we,
  input  logic [ILVL_W+1:0]            ps_wdata,
  output logic [VEC_W-1:0]             vec_q,
  output logic [ILVL_W+1:0]            ps_q,
  output logic [XLEN-1:0]              epc1_q,
  output logic [XLEN-1:0]              depc_q,
  output logic [CAUSE_W-1:0]           cause_q,
  output logic [XLEN-1:0]              vaddr_q,
  output logic [DCAUSE_W-1:0]          dcause_q,
  output logic [NUM_LEVELS-2:0][XLEN-1:0]     epc_bank,
  output logic [NUM_LEVELS-2:0][ILVL_W+1:0]   eps_bank
);
  localparam int PS_W   = ILVL_W + 2;
  localparam int EXCM_B = ILVL_W;
  localparam int UM_B   = ILVL_W + 1;
  localparam int NHI    = NUM_LEVELS - 1;
  localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);

  logic nested;
  assign nested = ps_q[EXCM_B];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q    <= '0;
      ps_q     <= '0;
      epc1_q   <= '0;
      cause_q  <= '0;
      vaddr_q  <= '0;
      dcause_q <= '0;
    end else begin
      vec_q <= '0;
      if (dbg_take) begin
        dcause_q         <= dbg_cause;
        ps_q             <= {ps_q[UM_B], 1'b1, LVL};
        vec_q[VEC_DEBUG] <= 1'b1;
      end else if (gen_take) begin
        cause_q <= gen_cause;
        if (gen_vaddr_we) vaddr_q <= gen_vaddr;
        if (nested) begin
          vec_q[VEC_DOUBLE] <= 1'b1;
          if (!HAS_DEPC) epc1_q <= gen_pc;
        end else begin
          epc1_q <= gen_pc;
          if (ps_q[UM_B]) vec_q[VEC_USER] <= 1'b1;
          else            vec_q[VEC_KERNEL] <= 1'b1;
        end
        ps_q[EXCM_B] <= 1'b1;
      end else if (ps_we) begin
        ps_q <= ps_wdata;
      end
    end
  end

  generate
    if (HAS_DEPC) begin : g_depc
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                              depc_q <= '0;
        else if (gen_take && !dbg_take && nested) depc_q <= gen_pc;
      end
    end else begin : g_no_depc
      assign depc_q = '0;
    end
  endgenerate

  for (genvar i = 0; i < NHI; i++) begin : g_bank
    localparam bool_sel = ((i + 2) == DBG_LEVEL);
    if (bool_sel) begin : g_dbg_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          epc_bank[i] <= '0;
          eps_bank[i] <= '0;
        end else if (dbg_take) begin
          epc_bank[i] <= dbg_pc;
          eps_bank[i] <= ps_q;
        end
      end
    end else begin : g_idle_slot
      assign epc_bank[i] = '0;
      assign eps_bank[i] = '0;
    end
  end

  // R11
  a_r11_one_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vec_q));
  // R11: no pulse extends into a second cycle without a new request
  a_r11_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!gen_take && !dbg_take) |=> (vec_q == '0));
  // R3
  a_r3_double_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_take && !dbg_take && nested) |=> vec_q[VEC_DOUBLE]);
  // R4
  a_r4_excm_set: assert property (@(posedge clk) disable iff (!rst_n)
    (gen_take && !dbg_take) |=> ps_q[EXCM_B]);
  // R9
  a_r9_debug_level: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_take |=> (ps_q[ILVL_W-1:0] == LVL) && ps_q[EXCM_B]);
  // R12
  a_r12_ps_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ps_we && !gen_take && !dbg_take) |=> (ps_q == $past(ps_wdata)));

  logic unused_w;
  assign unused_w = ^PS_W;
endmodule

// File: rtl/exc_dispatch.sv
module exc_dispatch
  import exc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int CAUSE_W    = 6,
  parameter int DCAUSE_W   = 6,
  parameter int ILVL_W     = 4,
  parameter int NUM_LEVELS = 7,
  parameter int DBG_LEVEL  = 6,
  parameter bit HAS_DEPC   = 1'b1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               req_valid,
  output logic                               req_ready,
  input  logic [1:0]                         req_kind,
  input  logic [CAUSE_W-1:0]                 req_cause,
  input  logic [XLEN-1:0]                    req_pc,
  input  logic [XLEN-1:0]                    req_vaddr,
  input  logic                               req_is_fetch,
  input  logic                               cfg_unaligned_exc,
  input  logic                               cfg_hw_align,
  input  logic                               dbg_valid,
  input  logic [DCAUSE_W-1:0]                dbg_cause,
  input  logic [XLEN-1:0]                    dbg_pc,
  input  logic                               ps_wr_en,
  input  logic [ILVL_W+1:0]                  ps_wr_data,
  output logic [3:0]                         vec_pulse,
  output logic [ILVL_W+1:0]                  ps,
  output logic [XLEN-1:0]                    epc1,
  output logic [XLEN-1:0]                    depc,
  output logic [CAUSE_W-1:0]                 exccause,
  output logic [XLEN-1:0]                    excvaddr,
  output logic [DCAUSE_W-1:0]                debugcause,
  output logic [NUM_LEVELS-2:0][XLEN-1:0]    epc_lvl,
  output logic [NUM_LEVELS-2:0][ILVL_W+1:0]  eps_lvl
);
  localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);

  logic               dbg_take;
  logic               accept;
  logic               gen_take;
  logic [CAUSE_W-1:0] gen_cause;
  logic               gen_vaddr_we;
  logic [XLEN-1:0]    gen_vaddr;
  logic [VEC_W-1:0]   vec_q;

  exc_dbg_gate #(.ILVL_W(ILVL_W), .DBG_LEVEL(DBG_LEVEL)) u_gate (
    .dbg_valid (dbg_valid),
    .cur_level (ps[ILVL_W-1:0]),
    .dbg_take  (dbg_take)
  );

  assign req_ready = ~dbg_take;
  assign accept    = req_valid & req_ready;

  exc_classify #(.XLEN(XLEN), .CAUSE_W(CAUSE_W)) u_classify (
    .req_on       (accept),
    .kind         (req_kind),
    .cause_in     (req_cause),
    .pc           (req_pc),
    .vaddr_in     (req_vaddr),
    .is_fetch     (req_is_fetch),
    .unaligned_en (cfg_unaligned_exc),
    .hw_align     (cfg_hw_align),
    .take         (gen_take),
    .cause_out    (gen_cause),
    .vaddr_we     (gen_vaddr_we),
    .vaddr_out    (gen_vaddr)
  );

  exc_state #(
    .XLEN(XLEN), .CAUSE_W(CAUSE_W), .DCAUSE_W(DCAUSE_W), .ILVL_W(ILVL_W),
    .NUM_LEVELS(NUM_LEVELS), .DBG_LEVEL(DBG_LEVEL), .HAS_DEPC(HAS_DEPC)
  ) u_state (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_take     (gen_take),
    .gen_cause    (gen_cause),
    .gen_pc       (req_pc),
    .gen_vaddr_we (gen_vaddr_we),
    .gen_vaddr    (gen_vaddr),
    .dbg_take     (dbg_take),
    .dbg_cause    (dbg_cause),
    .dbg_pc       (dbg_pc),
    .ps_we        (ps_wr_en),
    .ps_wdata     (ps_wr_data),
    .vec_q        (vec_q),
    .ps_q         (ps),
    .epc1_q       (epc1),
    .depc_q       (depc),
    .cause_q      (exccause),
    .vaddr_q      (excvaddr),
    .dcause_q     (debugcause),
    .epc_bank     (epc_lvl),
    .eps_bank     (eps_lvl)
  );

  assign vec_pulse = vec_q;

  // R6: a suppressed misaligned access changes nothing
  a_r6_misalign_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 2'd2 && (!cfg_unaligned_exc || cfg_hw_align) && !ps_wr_en)
      |=> (vec_pulse == '0) && $stable(exccause) && $stable(excvaddr) && $stable(ps));
  // R8
  a_r8_debug_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_valid && ps[ILVL_W-1:0] >= LVL) |=> !vec_pulse[VEC_DEBUG]);
  // R10
  a_r10_stall_means_debug: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> vec_pulse[VEC_DEBUG]);
  // R7
  a_r7_fetch_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_kind == 2'd3 && req_is_fetch) |=> (excvaddr == $past(req_pc)));
endmodule

// File: tb/test_exc_dispatch.sv
module test_exc_dispatch;
  localparam int XLEN = 32, CW = 6, DW = 6, IW = 4, NL = 7, DBG = 6;
  localparam int PSW = IW + 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready, req_is_fetch = 0;
  logic [1:0] req_kind = 0;
  logic [CW-1:0] req_cause = 0;
  logic [XLEN-1:0] req_pc = 0, req_vaddr = 0, dbg_pc = 0;
  logic cfg_ua = 0, cfg_hw = 0, dbg_valid = 0, ps_wr_en = 0;
  logic [DW-1:0] dbg_cause = 0;
  logic [PSW-1:0] ps_wr_data = 0;
  logic [3:0] vec_pulse;
  logic [PSW-1:0] ps;
  logic [XLEN-1:0] epc1, depc, excvaddr;
  logic [CW-1:0] exccause;
  logic [DW-1:0] debugcause;
  logic [NL-2:0][XLEN-1:0] epc_lvl;
  logic [NL-2:0][PSW-1:0] eps_lvl;

  exc_dispatch i_exc_dispatch (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_cause(req_cause), .req_pc(req_pc), .req_vaddr(req_vaddr),
    .req_is_fetch(req_is_fetch), .cfg_unaligned_exc(cfg_ua), .cfg_hw_align(cfg_hw),
    .dbg_valid(dbg_valid), .dbg_cause(dbg_cause), .dbg_pc(dbg_pc),
    .ps_wr_en(ps_wr_en), .ps_wr_data(ps_wr_data), .vec_pulse(vec_pulse), .ps(ps),
    .epc1(epc1), .depc(depc), .exccause(exccause), .excvaddr(excvaddr),
    .debugcause(debugcause), .epc_lvl(epc_lvl), .eps_lvl(eps_lvl)
  );

  always #4 clk = ~clk;

  typedef struct {
    int unsigned     due;
    logic [3:0]      vec;
    logic [PSW-1:0]  ps;
    logic [XLEN-1:0] epc1, depc, va, epcd;
    logic [CW-1:0]   cause;
    logic [DW-1:0]   dc;
    logic [PSW-1:0]  epsd;
    string           tag;
  } exp_t;

  exp_t q[$];
  int unsigned cyc = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  logic [PSW-1:0]  m_ps = 0;
  logic [XLEN-1:0] m_epc1 = 0, m_depc = 0, m_va = 0, m_epcd = 0;
  logic [CW-1:0]   m_cause = 0;
  logic [DW-1:0]   m_dc = 0;
  logic [PSW-1:0]  m_epsd = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic fail_line(string tag, string what, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
    $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // monitor: compare outputs one cycle after each driven vector
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      bit bad;
      e = q.pop_front();
      bad = 0;
      checks++;
      if (vec_pulse !== e.vec) begin bad = 1; fail_line(e.tag, "vec_pulse", 32'(vec_pulse), 32'(e.vec)); end
      if (ps !== e.ps) begin bad = 1; fail_line(e.tag, "ps", 32'(ps), 32'(e.ps)); end
      if (epc1 !== e.epc1) begin bad = 1; fail_line(e.tag, "epc1", epc1, e.epc1); end
      if (depc !== e.depc) begin bad = 1; fail_line(e.tag, "depc", depc, e.depc); end
      if (exccause !== e.cause) begin bad = 1; fail_line(e.tag, "exccause", 32'(exccause), 32'(e.cause)); end
      if (excvaddr !== e.va) begin bad = 1; fail_line(e.tag, "excvaddr", excvaddr, e.va); end
      if (debugcause !== e.dc) begin bad = 1; fail_line(e.tag, "debugcause", 32'(debugcause), 32'(e.dc)); end
      if (epc_lvl[DBG-2] !== e.epcd) begin bad = 1; fail_line(e.tag, "epc_dbg", epc_lvl[DBG-2], e.epcd); end
      if (eps_lvl[DBG-2] !== e.epsd) begin bad = 1; fail_line(e.tag, "eps_dbg", 32'(eps_lvl[DBG-2]), 32'(e.epsd)); end
      if (bad) fails++;
      checks++;
      if ($countones(vec_pulse) > 1) begin
        fails++;
        fail_line("R11", "vec_pulse onehot", 32'(vec_pulse), 32'(e.vec));
      end
    end
  end

  // driver: called at a negative edge, applies one cycle of stimulus
  task automatic drive(bit gv, logic [1:0] kind, logic [CW-1:0] cause, logic [XLEN-1:0] pc,
                       logic [XLEN-1:0] va, bit fetch, bit dv, logic [DW-1:0] dcause,
                       logic [XLEN-1:0] dpc, bit psw, logic [PSW-1:0] psd, string tag);
    exp_t e;
    bit dt, gt, vwe, rdy;
    logic [CW-1:0] gc;
    logic [XLEN-1:0] gva;
    logic [3:0] v;
    req_valid = gv; req_kind = kind; req_cause = cause; req_pc = pc; req_vaddr = va;
    req_is_fetch = fetch; dbg_valid = dv; dbg_cause = dcause; dbg_pc = dpc;
    ps_wr_en = psw; ps_wr_data = psd;
    dt = dv && (m_ps[IW-1:0] < IW'(DBG));
    rdy = !dt;
    gt = 0; vwe = 0; gc = cause; gva = va; v = 0;
    if (gv && rdy) begin
      case (kind)
        2'd0: gt = 1;
        2'd1: begin gt = 1; vwe = 1; end
        2'd2: if (cfg_ua && !cfg_hw) begin gt = 1; vwe = 1; gc = 9; end
        default: begin gt = 1; vwe = 1; gc = fetch ? 6'd12 : 6'd13; gva = fetch ? pc : va; end
      endcase
    end
    if (dt) begin
      m_dc = dcause; m_epcd = dpc; m_epsd = m_ps;
      m_ps = {m_ps[IW+1], 1'b1, IW'(DBG)}; v = 4'b1000;
    end else if (gt) begin
      m_cause = gc;
      if (vwe) m_va = gva;
      if (m_ps[IW]) begin v = 4'b0100; m_depc = pc; end
      else begin m_epc1 = pc; v = m_ps[IW+1] ? 4'b0001 : 4'b0010; end
      m_ps[IW] = 1'b1;
    end else if (psw) m_ps = psd;
    #1;
    checks++;
    if (req_ready !== rdy) begin
      fails++;
      fail_line({tag, " R10"}, "req_ready", 32'(req_ready), 32'(rdy));
    end
    e.due = cyc + 1; e.vec = v; e.ps = m_ps; e.epc1 = m_epc1; e.depc = m_depc;
    e.va = m_va; e.epcd = m_epcd; e.cause = m_cause; e.dc = m_dc; e.epsd = m_epsd; e.tag = tag;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic wps(logic [PSW-1:0] d, string tag);
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R1 reset state");
    // PS encoding: [3:0] INTLEVEL, [4] EXCM, [5] UM
    drive(1, 0, 6'd5, 32'h1000, 0, 0, 0, 0, 0, 0, 0, "R2 R4 kernel entry");
    idle("R11 pulse ends");
    drive(1, 0, 6'd7, 32'h2000, 0, 0, 0, 0, 0, 0, 0, "R3 double to depc");
    wps(6'b10_0010, "R12 ps write user");
    drive(1, 1, 6'd3, 32'h3000, 32'hdead_beef, 0, 0, 0, 0, 0, 0, "R5 R2 user addr fault");
    wps(6'b00_0000, "R12 ps clear");
    drive(1, 0, 6'd4, 32'h3100, 32'h1111_2222, 0, 0, 0, 0, 0, 0, "R5 plain keeps vaddr");
    wps(6'b00_0000, "R12 ps clear");
    cfg_ua = 1; cfg_hw = 0;
    drive(1, 2, 6'd1, 32'h4000, 32'h0000_4003, 0, 0, 0, 0, 0, 0, "R6 misalign trap");
    wps(6'b00_0000, "R12 ps clear");
    cfg_hw = 1;
    drive(1, 2, 6'd1, 32'h4100, 32'h0000_4101, 0, 0, 0, 0, 0, 0, "R6 hw align ignored");
    cfg_ua = 0; cfg_hw = 0;
    drive(1, 2, 6'd1, 32'h4200, 32'h0000_4202, 0, 0, 0, 0, 0, 0, "R6 disabled ignored");
    drive(1, 3, 6'd0, 32'h5000, 32'h9999_0000, 1, 0, 0, 0, 0, 0, "R7 fetch bus error");
    wps(6'b00_0000, "R12 ps clear");
    drive(1, 3, 6'd0, 32'h5100, 32'h8888_0004, 0, 0, 0, 0, 0, 0, "R7 data bus error");
    wps(6'b00_0110, "R12 ilvl 6");
    drive(0, 0, 0, 0, 0, 0, 1, 6'd2, 32'h6000, 0, 0, "R8 gated at equal level");
    wps(6'b00_0111, "R12 ilvl 7");
    drive(0, 0, 0, 0, 0, 0, 1, 6'd2, 32'h6100, 0, 0, "R8 gated above level");
    wps(6'b10_0101, "R12 ilvl 5 user");
    drive(0, 0, 0, 0, 0, 0, 1, 6'd33, 32'h6200, 0, 0, "R9 debug entry");
    drive(1, 0, 6'd2, 32'h6300, 0, 0, 0, 0, 0, 1, 6'b00_0000, "R12 write ignored on exception");
    wps(6'b00_0000, "R12 ps clear");
    drive(1, 0, 6'd6, 32'h7000, 0, 0, 1, 6'd17, 32'h7004, 0, 0, "R10 debug wins");
    drive(1, 0, 6'd6, 32'h7000, 0, 0, 0, 0, 0, 0, 0, "R10 held request double");
    wps(6'b00_0110, "R12 ilvl 6");
    drive(1, 0, 6'd8, 32'h7100, 0, 0, 1, 6'd18, 32'h7104, 0, 0, "R8 R10 gated debug lets request pass");
    idle("R11 idle");
    idle("R11 idle end");
    repeat (3) @(negedge clk);
    if (q.size() != 0) begin
      fails++;
      $display("FAIL R11 pending expectations actual=%0d expected=0", q.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule